// File: doc/BRIEF.md
# Configuration Register Bank with Guarded Reserved Slot

This block holds the configuration state of a larger design behind a simple single-master register bus. The bus carries a 4-bit address, a write strobe with 32-bit write data, and a read strobe with registered 32-bit read data. The sixteen locations are laid out as follows. A control word sits at the bottom. Thirteen general configuration words follow it. Above those is a status word, and the top location is reserved.

The reserved location is inert. A write to it alters no stored word and no output, and it is dropped. The only thing it does is set a sticky error line, which software clears through the status word. Reading the reserved location returns zero. The decoder ends in a default no-op branch, so any address it does not recognise cannot reach hidden logic.

A single general-purpose output comes from the control word. It is high only when software has set both the value bit and the enable bit of that word. It stays low in normal operation, and no access to the reserved location can raise it.

Top module: `cfg_regbank`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `rdata`, `gpio_o` and `err_o` are 0, and every location reads back as 0.
- R2: A write to addresses 0x00 through 0x0D stores all 32 bits of `wdata`, and a later read of that address returns the stored value.
- R3: A write to the reserved address 0x0F changes no stored word and leaves `gpio_o` unchanged.
- R4: A write to the reserved address 0x0F sets `err_o` on the next clock edge.
- R5: `err_o` stays set until a write to 0x0E with `wdata` bit 0 equal to 1 clears it. A write to 0x0E with bit 0 equal to 0 leaves it set. Reading 0x0E returns `err_o` in bit 0 and zeros in bits 31:1.
- R6: `gpio_o` equals bit 0 (value) AND bit 1 (enable) of the control word at 0x00. It goes high only after a write to 0x00 that sets both bits.
- R7: A read of the reserved address 0x0F returns 0 and leaves `err_o` and all stored words unchanged.
- R8: `rdata` updates on the clock edge that samples `rd_en` high, with the contents the location held before that edge. `rdata` holds its value while `rd_en` is low.
- R9: Reset is asserted asynchronously on `rst_n` low. Its release reaches the register logic two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| gpio_o | output | 1 | Output derived from the control word |
| err_o | output | 1 | Sticky reserved-write error |

## Verification
Every result is due one clock edge after the stimulus that causes it. Read data appears on the edge that samples `rd_en`. `err_o` and `gpio_o` follow the edge that samples the write. The bench drives each access on a falling edge, lets one rising edge pass and compares at the next falling edge, so each comparison lands exactly one edge after its cause. After reset is released, the bench waits out the two synchronizer edges before its first access. Random accesses are compared against a bench model of all sixteen locations, the error flag and the output pin.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  // Field positions inside the control and status words
  localparam int unsigned CTRL_VAL_BIT = 0;
  localparam int unsigned CTRL_EN_BIT  = 1;
  localparam int unsigned STAT_ERR_BIT = 0;

  // How the decoder treats an address
  typedef enum logic [1:0] {
    LOC_STORE  = 2'd0,
    LOC_STATUS = 2'd1,
    LOC_RSVD   = 2'd2,
    LOC_NONE   = 2'd3
  } loc_kind_e;

  function automatic loc_kind_e classify_loc(input int unsigned a,
                                             input int unsigned stat_a,
                                             input int unsigned rsvd_a,
                                             input int unsigned last_store);
    if (a == rsvd_a)          return LOC_RSVD;
    else if (a == stat_a)     return LOC_STATUS;
    else if (a <= last_store) return LOC_STORE;
    else                      return LOC_NONE;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STAT_ADDR  = 14,
  parameter int unsigned RSVD_ADDR  = 15,
  parameter int unsigned LAST_STORE = 13,
  localparam int unsigned NUM_LOC   = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_LOC-1:0] wr_stb,
  output logic              rsvd_wr,
  output logic              err_clr
);
  loc_kind_e kind;

  always_comb begin
    kind = classify_loc(int'(addr), STAT_ADDR, RSVD_ADDR, LAST_STORE);
  end

  always_comb begin
    wr_stb  = '0;
    rsvd_wr = 1'b0;
    err_clr = 1'b0;
    if (wr_en) begin
      case (kind)
        LOC_STORE:  wr_stb[addr] = 1'b1;
        LOC_STATUS: err_clr      = wdata[STAT_ERR_BIT];
        LOC_RSVD:   rsvd_wr      = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_word.sv
module cfg_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load) q_next = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/cfg_err_flag.sv
module cfg_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_next;

  always_comb begin
    flag_next = flag_o;
    if (clr_i) flag_next = 1'b0;
    if (set_i) flag_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next;
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 14,
  parameter int unsigned RSVD_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              gpio_o,
  output logic              err_o
);
  localparam int unsigned NUM_LOC    = 1 << ADDR_W;
  localparam int unsigned LAST_STORE = STAT_ADDR - 1;

  logic                rst_core_n;
  logic [NUM_LOC-1:0]  wr_stb;
  logic                rsvd_wr;
  logic                err_clr;
  logic [DATA_W-1:0]   loc_q [NUM_LOC];
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_next;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  cfg_addr_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STAT_ADDR  (STAT_ADDR),
    .RSVD_ADDR  (RSVD_ADDR),
    .LAST_STORE (LAST_STORE)
  ) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .wr_stb  (wr_stb),
    .rsvd_wr (rsvd_wr),
    .err_clr (err_clr)
  );

  // Storage only where the decoder classifies a location as storage
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    if (classify_loc(i, STAT_ADDR, RSVD_ADDR, LAST_STORE) == LOC_STORE) begin : g_store
      cfg_word #(.DATA_W(DATA_W)) u_word (
        .clk   (clk),
        .rst_n (rst_core_n),
        .load  (wr_stb[i]),
        .din   (wdata),
        .q     (loc_q[i])
      );
    end else begin : g_empty
      assign loc_q[i] = '0;
    end
  end

  cfg_err_flag u_err (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set_i  (rsvd_wr),
    .clr_i  (err_clr),
    .flag_o (err_o)
  );

  // Read selection: status word is assembled, reserved and empty read zero
  always_comb begin
    rd_val = '0;
    case (classify_loc(int'(addr), STAT_ADDR, RSVD_ADDR, LAST_STORE))
      LOC_STORE:  rd_val = loc_q[addr];
      LOC_STATUS: rd_val[STAT_ERR_BIT] = err_o;
      default:    rd_val = '0;
    endcase
  end

  always_comb begin
    rdata_next = rdata;
    if (rd_en) rdata_next = rd_val;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata <= '0;
    else             rdata <= rdata_next;
  end

  assign gpio_o = loc_q[CTRL_ADDR][CTRL_VAL_BIT] & loc_q[CTRL_ADDR][CTRL_EN_BIT];

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 14,
  parameter int unsigned RSVD_ADDR = 15
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              gpio_o,
  input logic              err_o
);
  logic hit_rsvd, hit_stat, hit_ctrl;
  assign hit_rsvd = (int'(addr) == RSVD_ADDR);
  assign hit_stat = (int'(addr) == STAT_ADDR);
  assign hit_ctrl = (int'(addr) == CTRL_ADDR);

  // R1 / R9
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_core_n |-> (rdata == '0 && !gpio_o && !err_o));

  // R3
  a_r3_rsvd_keeps_gpio: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && hit_rsvd) |=> $stable(gpio_o));

  // R4
  a_r4_rsvd_sets_err: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && hit_rsvd) |=> err_o);

  // R5
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    (err_o && !(wr_en && hit_stat && wdata[0])) |=> err_o);

  a_r5_err_only_from_rsvd: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(err_o) |-> $past(wr_en && hit_rsvd));

  // R6
  a_r6_gpio_from_ctrl: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(gpio_o) |-> $past(wr_en && hit_ctrl && wdata[0] && wdata[1]));

  // R7
  a_r7_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && hit_rsvd) |=> (rdata == '0));

  // R8
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_en |=> $stable(rdata));
endmodule

bind cfg_regbank cfg_regbank_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CTRL_ADDR (CTRL_ADDR),
  .STAT_ADDR (STAT_ADDR),
  .RSVD_ADDR (RSVD_ADDR)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .gpio_o     (gpio_o),
  .err_o      (err_o)
);

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic        rd_en;
  logic [31:0] rdata;
  logic        gpio_o;
  logic        err_o;

  int n_tests;
  int n_fail;
  logic [31:0] mdl [16];
  logic        mdl_err;

  cfg_regbank dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .gpio_o(gpio_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    if (a == 4'hF)      return 32'h0;
    else if (a == 4'hE) return {31'h0, mdl_err};
    else                return mdl[a];
  endfunction

  function automatic logic exp_gpio();
    return mdl[0][0] & mdl[0][1];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    if (a == 4'hF)      mdl_err = 1'b1;
    else if (a == 4'hE) begin if (d[0]) mdl_err = 1'b0; end
    else                mdl[a] = d;
  endtask

  // Drive at negedge, edge captures, compare at the following negedge
  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input string req);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check(req, {31'h0, gpio_o}, {31'h0, exp_gpio()});
    check(req, {31'h0, err_o}, {31'h0, mdl_err});
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, e);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    n_tests = 0; n_fail = 0;
    addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    mdl_err = 1'b0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check("R1", rdata, 32'h0);
    check("R1", {31'h0, gpio_o}, 32'h0);
    check("R1", {31'h0, err_o}, 32'h0);
    rst_n = 1'b1;
    // R9: two synchronizer edges before registers leave reset
    repeat (3) @(negedge clk);
    for (int a = 0; a < 16; a++) do_read(4'(a), "R1");

    // R2: walk storage locations
    for (int a = 0; a < 14; a++) do_write(4'(a), 32'hA5000000 | 32'(a) << 4 | 32'h3 & ~32'h3, "R2");
    for (int a = 0; a < 14; a++) do_read(4'(a), "R2");

    // R6: enable without value, value without enable, both
    do_write(4'h0, 32'h0000_0002, "R6");
    do_write(4'h0, 32'h0000_0001, "R6");
    do_write(4'h0, 32'h0000_0003, "R6");
    do_write(4'h0, 32'hFFFF_FFFC, "R6");

    // R3 / R4: reserved write changes nothing, raises error
    do_write(4'hF, 32'hFFFF_FFFF, "R3 R4");
    for (int a = 0; a < 14; a++) do_read(4'(a), "R3");
    check("R3", {31'h0, gpio_o}, 32'h0);
    // R7: reserved read is zero and leaves the flag
    do_read(4'hF, "R7");
    check("R7", {31'h0, err_o}, 32'h1);
    // R5: status read, clear with bit0=0 keeps it, bit0=1 clears
    do_read(4'hE, "R5");
    do_write(4'hE, 32'hFFFF_FFFE, "R5");
    do_read(4'hE, "R5");
    do_write(4'hE, 32'h0000_0001, "R5");
    do_read(4'hE, "R5");
    // R3: reserved write while gpio high keeps it high
    do_write(4'h0, 32'h0000_0003, "R6");
    do_write(4'hF, 32'h0, "R3");
    check("R3", {31'h0, gpio_o}, 32'h1);
    do_write(4'hE, 32'h1, "R5");

    // R8: same-edge write and read returns old contents
    addr = 4'h5; wdata = 32'hDEAD_BEEF; wr_en = 1; rd_en = 1;
    held = mdl[5];
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0;
    mdl[5] = 32'hDEAD_BEEF;
    check("R8", rdata, held);
    // R8: rdata holds while rd_en low
    do_write(4'h5, 32'h1234_5678, "R8");
    check("R8", rdata, held);
    do_read(4'h5, "R8");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic [3:0] ra;
      ra = 4'($urandom % 16);
      if ($urandom % 2 == 0) do_write(ra, $urandom, "R2 R3 R4 R5 R6");
      else                   do_read(ra, "R2 R5 R7 R8");
    end

    // R9: asynchronous assertion mid-cycle
    do_write(4'h0, 32'h3, "R6");
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R9", {31'h0, gpio_o}, 32'h0);
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    mdl_err = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(4'h0, "R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule